// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block re-times the address and command lines of a registered memory module. It takes a wide input word on each rising clock edge and drives it out one cycle later from flip-flops. Two static configuration pins pick the layout. In the narrow-copy layout each of 25 inputs drives one output. In the duplicate layout each of 14 inputs drives two outputs. For the duplicate layout, a second pin picks how the two copies sit on the output bus: as two separate halves, or as neighbouring pairs.

A pair of select inputs can freeze the outputs. When both are high at a rising edge, the outputs keep their previous value. When either is low, the buffer loads normally. An active-low reset clears every output at once, without waiting for a clock, and it overrides the freeze. Release of the reset passes through a two-stage synchroniser, so the first load happens on a clean clock edge.

Top module: `regbuf_fanout`

## Requirements
- R1: While `rst_n` is low, every bit of `q_out` is 0. A fall of `rst_n` clears `q_out` before the next rising clock edge.
- R2: After `rst_n` rises between two clock edges, the first and second rising edges that follow leave `q_out` at 0. The third rising edge is the first one that loads data.
- R3: With `wide_mode` = 0, a loading edge sets `q_out[i]` to the `d_in[i]` presented before that edge, for i = 0..24, and holds `q_out[27:25]` at 0.
- R4: With `wide_mode` = 1 and `layout_b` = 0, a loading edge sets both `q_out[i]` and `q_out[i+14]` to `d_in[i]`, for i = 0..13. `d_in[24:14]` has no effect on `q_out`.
- R5: With `wide_mode` = 1 and `layout_b` = 1, a loading edge sets both `q_out[2i]` and `q_out[2i+1]` to `d_in[i]`, for i = 0..13. `d_in[24:14]` has no effect on `q_out`.
- R6: A rising edge at which `hold_a` and `hold_b` are both 1 leaves `q_out` unchanged, whatever `d_in` is.
- R7: A rising edge at which exactly one of `hold_a` and `hold_b` is 1 loads `q_out` just as an edge with both at 0 does.
- R8: A fall of `rst_n` clears `q_out` even while both hold inputs are 1.
- R9: After reset is released with `d_in` at 0 and the clock running, `q_out` stays at 0 on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| wide_mode | input | 1 | 0 = 25 one-to-one bits; 1 = 14 bits, each with two output copies. Static outside reset |
| layout_b | input | 1 | Duplicate layout: 0 = copies in two halves, 1 = copies on adjacent indices. Static outside reset |
| hold_a | input | 1 | First freeze select; together with `hold_b` high, it blocks the load |
| hold_b | input | 1 | Second freeze select |
| d_in | input | 25 | Address/command input word |
| q_out | output | 28 | Registered output bus |

## Verification
The bench builds the block with its default widths: 25 single-copy bits and 14 duplicated bits. This gives a 28-bit output bus, which is wider than the single-copy layout. Outputs 25 to 27 are therefore idle in that layout, and the inputs above bit 13 are dead in both duplicate layouts, so both kinds of ignored pin can be checked at the ports. With these defaults all three layouts, each freeze combination, and the three-edge reset release window can be reached.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  typedef enum logic [1:0] {
    MAP_SINGLE     = 2'd0,
    MAP_DUAL_SPLIT = 2'd1,
    MAP_DUAL_PAIR  = 2'd2
  } map_mode_e;

  function automatic map_mode_e decode_mode(input logic wide, input logic pair_layout);
    if (!wide)           return MAP_SINGLE;
    else if (pair_layout) return MAP_DUAL_PAIR;
    else                 return MAP_DUAL_SPLIT;
  endfunction

  function automatic int bus_width(input int single_w, input int dual_w);
    return (2 * dual_w > single_w) ? 2 * dual_w : single_w;
  endfunction

endpackage

// File: rtl/regbuf_rst_sync.sv
module regbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], 1'b1};
  end

  assign run = stg[STAGES-1];

  // R2: once running, the buffer stays running until reset falls again
  assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);

endmodule

// File: rtl/regbuf_lane_map.sv
module regbuf_lane_map
  import regbuf_pkg::*;
#(
  parameter int SINGLE_W = 25,
  parameter int DUAL_W   = 14,
  localparam int OUT_W   = bus_width(SINGLE_W, DUAL_W)
) (
  input  map_mode_e           mode,
  input  logic [SINGLE_W-1:0] d,
  output logic [OUT_W-1:0]    y
);

  for (genvar j = 0; j < OUT_W; j++) begin : g_lane
    localparam bit HAS_S = (j < SINGLE_W);
    localparam bit HAS_D = (j < 2 * DUAL_W);
    localparam int S_IDX = HAS_S ? j : 0;
    localparam int A_IDX = HAS_D ? (j % DUAL_W) : 0;
    localparam int B_IDX = HAS_D ? (j / 2) : 0;

    logic s_bit, a_bit, b_bit;
    assign s_bit = HAS_S ? d[S_IDX] : 1'b0;
    assign a_bit = HAS_D ? d[A_IDX] : 1'b0;
    assign b_bit = HAS_D ? d[B_IDX] : 1'b0;

    always_comb begin
      unique case (mode)
        MAP_SINGLE:     y[j] = s_bit;
        MAP_DUAL_SPLIT: y[j] = a_bit;
        MAP_DUAL_PAIR:  y[j] = b_bit;
        default:        y[j] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/regbuf_out_reg.sv
module regbuf_out_reg #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d_next,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d_next;
  end

endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout
  import regbuf_pkg::*;
#(
  parameter int SINGLE_W    = 25,
  parameter int DUAL_W      = 14,
  parameter int SYNC_STAGES = 2,
  localparam int OUT_W      = bus_width(SINGLE_W, DUAL_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic                layout_b,
  input  logic                hold_a,
  input  logic                hold_b,
  input  logic [SINGLE_W-1:0] d_in,
  output logic [OUT_W-1:0]    q_out
);

  logic            run;
  logic            freeze;
  logic            load_en;
  map_mode_e       mode;
  logic [OUT_W-1:0] lane_vec;

  regbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  assign mode = decode_mode(wide_mode, layout_b);

  regbuf_lane_map #(.SINGLE_W(SINGLE_W), .DUAL_W(DUAL_W)) u_map (
    .mode (mode),
    .d    (d_in),
    .y    (lane_vec)
  );

  assign freeze  = hold_a & hold_b;
  assign load_en = run & ~freeze;

  regbuf_out_reg #(.W(OUT_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .d_next  (lane_vec),
    .q       (q_out)
  );

  // R6: both selects high at a running edge keep the outputs
  assert_freeze_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold_a && hold_b) |=> $stable(q_out));

  // R7: any select low at a running edge loads the mapped word
  assert_load_mapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(hold_a && hold_b)) |=> (q_out == $past(lane_vec)));

  // R2: no load reaches the outputs before the release synchroniser finishes
  assert_quiet_until_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (q_out == '0));

  if (OUT_W > SINGLE_W) begin : g_idle_single
    // R3: pins above the single-copy width stay low in that layout
    assert_idle_high_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |-> (q_out[OUT_W-1:SINGLE_W] == '0));
  end

  for (genvar i = 0; i < DUAL_W; i++) begin : g_dup_chk
    // R4: split layout mirrors bit i on index i+DUAL_W
    assert_split_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode && !layout_b) |-> (q_out[i] == q_out[i+DUAL_W]));
    // R5: pair layout mirrors bit i on indices 2i and 2i+1
    assert_pair_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode && layout_b) |-> (q_out[2*i] == q_out[2*i+1]));
  end

endmodule

// File: tb/regbuf_fanout_tb_top.sv
`timescale 1ns/1ps
module regbuf_fanout_tb_top;

  localparam int SW = 25;
  localparam int DW = 14;
  localparam int OW = 28;
  localparam int NV = 12;

  // {wide_mode, layout_b, hold_a, hold_b, d_in[24:0]}
  localparam logic [28:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 25'h1ABCDEF},
    {1'b0, 1'b0, 1'b1, 1'b0, 25'h0F0F0F0},
    {1'b0, 1'b0, 1'b1, 1'b1, 25'h1555555},
    {1'b0, 1'b0, 1'b0, 1'b1, 25'h1FFFFFF},
    {1'b1, 1'b0, 1'b0, 1'b0, 25'h1FE2A5A},
    {1'b1, 1'b0, 1'b1, 1'b1, 25'h0001234},
    {1'b1, 1'b0, 1'b0, 1'b0, 25'h1FFC001},
    {1'b1, 1'b1, 1'b0, 1'b0, 25'h0003A5C},
    {1'b1, 1'b1, 1'b0, 1'b1, 25'h1FC2222},
    {1'b1, 1'b1, 1'b1, 1'b1, 25'h0000FFF},
    {1'b1, 1'b1, 1'b1, 1'b0, 25'h0001001},
    {1'b0, 1'b0, 1'b0, 1'b0, 25'h0000001}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_mode = 1'b0;
  logic          layout_b = 1'b0;
  logic          hold_a = 1'b0;
  logic          hold_b = 1'b0;
  logic [SW-1:0] d_in = '0;
  logic [OW-1:0] q_out;
  logic [OW-1:0] exp_q = '0;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2.5 clk = ~clk;

  regbuf_fanout dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .layout_b  (layout_b),
    .hold_a    (hold_a),
    .hold_b    (hold_b),
    .d_in      (d_in),
    .q_out     (q_out)
  );

  function automatic logic [OW-1:0] model(input logic w, input logic lb, input logic [SW-1:0] dv);
    logic [OW-1:0] r = '0;
    if (!w) begin
      for (int i = 0; i < SW; i++) r[i] = dv[i];
    end else if (!lb) begin
      for (int i = 0; i < DW; i++) begin r[i] = dv[i]; r[i+DW] = dv[i]; end
    end else begin
      for (int i = 0; i < DW; i++) begin r[2*i] = dv[i]; r[2*i+1] = dv[i]; end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic apply_reset(input logic w, input logic lb);
    @(negedge clk);
    rst_n = 1'b0; wide_mode = w; layout_b = lb;
    hold_a = 1'b0; hold_b = 1'b0; d_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_q = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R1 reset state", q_out, '0);
    apply_reset(1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k][28] != wide_mode || VECS[k][27] != layout_b)
        apply_reset(VECS[k][28], VECS[k][27]);
      hold_a = VECS[k][26];
      hold_b = VECS[k][25];
      d_in   = VECS[k][24:0];
      @(negedge clk);
      if (!(hold_a && hold_b)) exp_q = model(wide_mode, layout_b, d_in);
      if (hold_a && hold_b)       tag = "R6 both selects freeze";
      else if (hold_a ^ hold_b)   tag = "R7 one select high loads";
      else if (!wide_mode)        tag = "R3 single layout";
      else if (!layout_b)         tag = "R4 split layout";
      else                        tag = "R5 pair layout";
      check(tag, q_out, exp_q);
    end

    // R1: asynchronous clear before the next edge, then held low
    hold_a = 1'b0; hold_b = 1'b0; d_in = '1;
    @(negedge clk);
    check("R3 all ones", q_out, {3'b000, 25'h1FFFFFF});
    #1 rst_n = 1'b0;
    #0.5 check("R1 immediate clear", q_out, '0);
    repeat (3) begin
      @(negedge clk);
      check("R1 held low in reset", q_out, '0);
    end

    // R2: release mid-cycle with data present
    rst_n = 1'b1;
    @(negedge clk); check("R2 first edge after release", q_out, '0);
    @(negedge clk); check("R2 second edge after release", q_out, '0);
    @(negedge clk); check("R2 third edge loads", q_out, {3'b000, 25'h1FFFFFF});

    // R8: reset wins over a freeze
    hold_a = 1'b1; hold_b = 1'b1; d_in = '0;
    @(negedge clk);
    check("R6 frozen against zero data", q_out, {3'b000, 25'h1FFFFFF});
    #1 rst_n = 1'b0;
    #0.5 check("R8 reset overrides freeze", q_out, '0);
    @(negedge clk);
    hold_a = 1'b0; hold_b = 1'b0; d_in = '0;
    rst_n = 1'b1;

    // R9: quiet release
    repeat (6) begin
      @(negedge clk);
      check("R9 low data stays low", q_out, '0);
    end

    // R4 / R5: upper inputs ignored in duplicate layouts
    apply_reset(1'b1, 1'b0);
    d_in = 25'h1FFC000;
    @(negedge clk);
    check("R4 upper inputs ignored", q_out, '0);
    apply_reset(1'b1, 1'b1);
    d_in = 25'h1FFC000;
    @(negedge clk);
    check("R5 upper inputs ignored", q_out, '0);
    d_in = 25'h0002001;
    @(negedge clk);
    check("R5 pair placement", q_out, 28'hC000003);

    finish_run();
  end

endmodule